// File: doc/BRIEF.md
# Interrupt Entry Arbiter

This block is the front end that decides when a small 8-bit processor core leaves its instruction stream to enter an interrupt handler. It watches two active-low request lines. One is a maskable request that acts on its level and is gated by an interrupt-mask flag. The other is a non-maskable request that acts only on a high-to-low transition of its line. At each instruction boundary that the core reports, the block either stays quiet or issues a one-cycle take pulse together with a vector code that selects the handler.

The block owns the mask flag. Entering an interrupt sets the flag. A clear-mask instruction clears it. A return-from-interrupt restores the value the flag had before the entry. Both the entry sequence and the return sequence are modelled as a busy window of fixed length. While that window is open, the block ignores boundaries and instruction strobes. A non-maskable edge that arrives during the window, or between two boundaries, is held in a pending flag until an entry consumes it.

Both request lines pass through a synchronizer whose depth is a parameter and may be zero.

Top module: `irq_entry_arb`

## Requirements
- R1: While the maskable line is low and the mask flag is 0, a boundary outside the busy window produces `take_int` = 1 with `vec_sel` = 2'b01 in the cycle after the boundary strobe.
- R2: If the maskable line is still low after a return restores a clear mask, the next boundary takes the maskable interrupt again.
- R3: A high-to-low transition of the non-maskable line is taken at the next free boundary with `vec_sel` = 2'b10, whatever the state of the mask flag.
- R4: A non-maskable line that stays low causes no further entry. Only a rise followed by a new fall arms it again.
- R5: When a non-maskable edge is pending and the maskable request is also valid at the same boundary, the non-maskable vector 2'b10 is chosen.
- R6: The mask flag is 1 after reset and is 1 in the cycle that `take_int` is high.
- R7: A return restores the mask flag to its value before the matching entry, whether or not any request line has been released.
- R8: A clear-mask strobe sets the flag to 0, so a maskable request can be taken inside a non-maskable handler before its return.
- R9: `seq_busy` is high for ENTRY_CYCLES (default 7) cycles starting with the take cycle. It is high for RET_CYCLES (default 6) cycles after an accepted return, so an entry followed at once by a return spans 13 cycles.
- R10: A non-maskable low pulse of one clock or more that occurs between boundaries, or inside the busy window, is remembered and taken at the next free boundary.
- R11: Boundaries and strobes are ignored while `seq_busy` is high. `take_int` lasts one cycle, and `vec_sel` is 2'b00 whenever `take_int` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Maskable request, active low, level sensitive |
| nmi_n | input | 1 | Non-maskable request, active low, edge sensitive |
| insn_end | input | 1 | Instruction boundary strobe |
| rti_done | input | 1 | Return-from-interrupt executed |
| cli_done | input | 1 | Clear-mask instruction executed |
| take_int | output | 1 | One-cycle pulse: an entry sequence starts |
| vec_sel | output | 2 | 00 none, 01 maskable, 10 non-maskable |
| mask_flag | output | 1 | Current interrupt-mask flag |
| seq_busy | output | 1 | Entry or return sequence in progress |

## Verification
The bench holds the non-maskable line low across a full entry and return. A level-triggered design would re-enter at the next boundary, and the bench checks that it does not. It also checks that the re-arm after a fresh high-to-low transition still works. It sends a one-cycle non-maskable pulse during an open busy window, where a detector without a latch would drop it, and it strobes a boundary inside that window, where a missing busy gate would start a second entry. The bench also checks the following:
- The mask value after a return with nothing acknowledged. A design that clears or keeps the flag instead of restoring it fails here.
- The re-entry of a maskable request that is never released.
- A clear-mask strobe inside the non-maskable handler.
- The exact 7 + 6 cycle busy windows.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   typedef enum logic [1:0] {
      VEC_NONE = 2'b00,
      VEC_IRQ  = 2'b01,
      VEC_NMI  = 2'b10
   } vec_e;
endpackage

// File: rtl/line_sync.sv
// Multi-stage synchronizer for an active-low request line; depth 0 is a wire.
module line_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 0) begin : g_bad_depth
      $error("line_sync: STAGES must be non-negative");
   end

   if (STAGES == 0) begin : g_wire
      assign dout = din;
   end else begin : g_chain
      logic [STAGES-1:0] shreg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) shreg <= {STAGES{RST_VAL}};
         else        shreg <= STAGES'({shreg, din});
      end
      assign dout = shreg[STAGES-1];
   end
endmodule

// File: rtl/nmi_edge_latch.sv
// Falling-edge detector with a pending flag held until an entry consumes it.
module nmi_edge_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic line_s,
   input  logic clr,
   output logic req
);
   logic prev_q;
   logic pend_q;
   logic fall;

   assign fall = prev_q & ~line_s;
   assign req  = pend_q | fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         pend_q <= 1'b0;
      end else begin
         prev_q <= line_s;
         pend_q <= (pend_q | fall) & ~clr;
      end
   end

   // R10: a latched edge is dropped only by an entry that consumes it
   assert_pend_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q) |-> $past(clr));
   // R4: a line held low never raises a new request on its own
   assert_no_level_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clr) && !line_s && !$past(line_s)) |-> !req);
endmodule

// File: rtl/seq_timer.sv
// Busy window modelling the cycle cost of entry and return sequences.
module seq_timer #(
   parameter int ENTRY_CYCLES = 7,
   parameter int RET_CYCLES   = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_entry,
   input  logic start_ret,
   output logic busy
);
   localparam int MAXC  = (ENTRY_CYCLES > RET_CYCLES) ? ENTRY_CYCLES : RET_CYCLES;
   localparam int CNT_W = $clog2(MAXC + 1);

   if (ENTRY_CYCLES < 1 || RET_CYCLES < 1) begin : g_bad_len
      $error("seq_timer: cycle counts must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (start_entry) cnt_q <= CNT_W'(ENTRY_CYCLES);
      else if (start_ret)   cnt_q <= CNT_W'(RET_CYCLES);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

   // R9: a busy window opens only on a started sequence
   assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start_entry || start_ret));
   // R11: no sequence is started while one is running
   assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(start_entry || start_ret));
endmodule

// File: rtl/mask_unit.sv
// Interrupt-mask flag with a one-level saved copy for the return sequence.
module mask_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic enter,
   input  logic ret,
   input  logic clr,
   output logic mask
);
   logic mask_q;
   logic saved_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= 1'b1;
         saved_q <= 1'b1;
      end else if (enter) begin
         saved_q <= mask_q;
         mask_q  <= 1'b1;
      end else if (ret) begin
         mask_q  <= saved_q;
      end else if (clr) begin
         mask_q  <= 1'b0;
      end
   end

   assign mask = mask_q;

   // R6: the flag only rises through an entry or a restoring return
   assert_mask_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mask_q) |-> $past(enter || ret));
   // R7/R8: the flag only falls through a return or a clear strobe
   assert_mask_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mask_q) |-> $past(ret || clr));
endmodule

// File: rtl/irq_entry_arb.sv
module irq_entry_arb #(
   parameter int SYNC_STAGES  = 2,
   parameter int ENTRY_CYCLES = 7,
   parameter int RET_CYCLES   = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       irq_n,
   input  logic       nmi_n,
   input  logic       insn_end,
   input  logic       rti_done,
   input  logic       cli_done,
   output logic       take_int,
   output logic [1:0] vec_sel,
   output logic       mask_flag,
   output logic       seq_busy
);
   import irq_arb_pkg::*;

   logic irq_s, nmi_s;
   logic nmi_req, irq_req;
   logic idle, take_nmi, take_irq, enter, ret_ok, clr_ok;
   logic take_q;
   vec_e vec_q;

   line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_irq_sync (
      .clk(clk), .rst_n(rst_n), .din(irq_n), .dout(irq_s));
   line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_nmi_sync (
      .clk(clk), .rst_n(rst_n), .din(nmi_n), .dout(nmi_s));

   nmi_edge_latch u_nmi_edge (
      .clk(clk), .rst_n(rst_n), .line_s(nmi_s), .clr(take_nmi), .req(nmi_req));

   assign idle     = ~seq_busy;
   assign irq_req  = ~irq_s & ~mask_flag;
   assign take_nmi = insn_end & idle & nmi_req;
   assign take_irq = insn_end & idle & ~nmi_req & irq_req;
   assign enter    = take_nmi | take_irq;
   assign ret_ok   = rti_done & idle & ~enter;
   assign clr_ok   = cli_done & idle & ~enter & ~rti_done;

   seq_timer #(.ENTRY_CYCLES(ENTRY_CYCLES), .RET_CYCLES(RET_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_entry(enter), .start_ret(ret_ok),
      .busy(seq_busy));

   mask_unit u_mask (
      .clk(clk), .rst_n(rst_n), .enter(enter), .ret(ret_ok), .clr(clr_ok),
      .mask(mask_flag));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_q <= 1'b0;
         vec_q  <= VEC_NONE;
      end else begin
         take_q <= enter;
         vec_q  <= take_nmi ? VEC_NMI : (take_irq ? VEC_IRQ : VEC_NONE);
      end
   end

   assign take_int = take_q;
   assign vec_sel  = vec_q;

   // R11: the take strobe is a single-cycle pulse
   assert_take_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      take_int |=> !take_int);
   // R11: a vector code is driven exactly when an entry starts
   assert_vec_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      take_int == (vec_sel != 2'b00));
   // R6: entry always leaves the mask flag set
   assert_mask_on_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take_int |-> mask_flag);
   // R9: the busy window covers the take cycle
   assert_busy_on_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
      take_int |-> seq_busy);
endmodule

// File: tb/tb_irq_entry_arb.sv
module tb_irq_entry_arb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq_n = 1'b1, nmi_n = 1'b1, insn_end = 1'b0, rti_done = 1'b0, cli_done = 1'b0;
   logic take_int, mask_flag, seq_busy;
   logic [1:0] vec_sel;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   localparam logic [1:0] V_NONE = 2'b00, V_IRQ = 2'b01, V_NMI = 2'b10;

   typedef struct packed {
      logic       irq_lvl_n;
      logic       nmi_fall;
      logic       do_cli;
      logic       exp_take;
      logic [1:0] exp_vec;
   } row_t;

   localparam int NROWS = 5;
   localparam row_t ROWS [NROWS] = '{
      '{1'b1, 1'b0, 1'b1, 1'b0, 2'b00},   // R1: no request, nothing taken
      '{1'b0, 1'b0, 1'b0, 1'b0, 2'b00},   // R6: masked level request held off
      '{1'b0, 1'b0, 1'b1, 1'b1, 2'b01},   // R1: level request with mask clear
      '{1'b1, 1'b1, 1'b0, 1'b1, 2'b10},   // R3: edge taken while masked
      '{1'b0, 1'b1, 1'b1, 1'b1, 2'b10}    // R5: edge wins over level
   };

   always #4 clk = ~clk;

   irq_entry_arb dut (
      .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
      .insn_end(insn_end), .rti_done(rti_done), .cli_done(cli_done),
      .take_int(take_int), .vec_sel(vec_sel), .mask_flag(mask_flag),
      .seq_busy(seq_busy));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; irq_n = 1'b1; nmi_n = 1'b1;
      insn_end = 1'b0; rti_done = 1'b0; cli_done = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic boundary();
      insn_end = 1'b1; @(negedge clk); insn_end = 1'b0;
   endtask

   task automatic do_cli();
      cli_done = 1'b1; @(negedge clk); cli_done = 1'b0;
   endtask

   task automatic do_rti();
      rti_done = 1'b1; @(negedge clk); rti_done = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (seq_busy && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      int n1, n2;
      @(negedge clk);
      do_reset();
      // R6 R11: reset state
      check("R6 reset mask", mask_flag, 1);
      check("R11 reset take", take_int, 0);
      check("R11 reset vec", vec_sel, V_NONE);
      check("R9 reset busy", seq_busy, 0);

      // table walk: R1 R3 R5 R6
      for (int i = 0; i < NROWS; i++) begin
         do_reset();
         if (ROWS[i].do_cli) do_cli();
         irq_n = ROWS[i].irq_lvl_n;
         if (ROWS[i].nmi_fall) nmi_n = 1'b0;
         settle();
         boundary();
         check($sformatf("R1/R3/R5 row %0d take", i), take_int, ROWS[i].exp_take);
         check($sformatf("R1/R3/R5 row %0d vec", i), vec_sel, ROWS[i].exp_vec);
         if (ROWS[i].exp_take) check($sformatf("R6 row %0d mask", i), mask_flag, 1);
      end

      // R9 R7 R4: held-low edge line, timing, restore
      do_reset(); do_cli();
      nmi_n = 1'b0; settle(); boundary();
      check("R3 nmi take", take_int, 1);
      wait_idle(n1);
      check("R9 entry cycles", n1, 7);
      do_rti();
      wait_idle(n2);
      check("R9 return cycles", n2, 6);
      check("R9 total cycles", n1 + n2, 13);
      check("R7 mask restored without ack", mask_flag, 0);
      boundary();
      check("R4 no retrigger while low", take_int, 0);
      nmi_n = 1'b1; settle(); nmi_n = 1'b0; settle(); boundary();
      check("R4 rearm take", take_int, 1);
      check("R4 rearm vec", vec_sel, V_NMI);

      // R2: unreleased level request re-enters after return
      do_reset(); do_cli();
      irq_n = 1'b0; settle(); boundary();
      check("R1 irq take", vec_sel, V_IRQ);
      wait_idle(n1); do_rti(); wait_idle(n1);
      check("R7 mask after irq return", mask_flag, 0);
      boundary();
      check("R2 retake", take_int, 1);
      check("R2 retake vec", vec_sel, V_IRQ);
      irq_n = 1'b1; wait_idle(n1); do_rti(); wait_idle(n1); settle();
      boundary();
      check("R1 released no take", take_int, 0);

      // R8: clear-mask inside the edge handler
      do_reset();
      irq_n = 1'b0; nmi_n = 1'b0; settle(); boundary();
      check("R3 nmi while masked", vec_sel, V_NMI);
      wait_idle(n1);
      boundary();
      check("R6 irq held off in handler", take_int, 0);
      do_cli();
      check("R8 mask cleared", mask_flag, 0);
      boundary();
      check("R8 irq inside handler", take_int, 1);
      check("R8 irq vec", vec_sel, V_IRQ);

      // R10 R11: short pulse during busy, boundary ignored while busy
      do_reset(); do_cli();
      irq_n = 1'b0; settle(); boundary();
      check("R1 irq before pulse", take_int, 1);
      nmi_n = 1'b0; @(negedge clk); nmi_n = 1'b1;
      settle();
      boundary();
      check("R11 boundary ignored while busy", take_int, 0);
      check("R11 vec idle", vec_sel, V_NONE);
      wait_idle(n1);
      boundary();
      check("R10 latched pulse taken", take_int, 1);
      check("R10 latched pulse vec", vec_sel, V_NMI);

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule